// File: doc/BRIEF.md
# Hub Configuration Register Bank with Strap Overlay

This block stores the configuration bytes of a USB hub in a small addressed register bank. One simple port reaches the bank. A serial management slave or a boot-time EEPROM loader can sit in front of it. The port has a write strobe, an 8-bit address, write data, and a read path that returns the byte at the current address in the same cycle. Eight registers are defined, at addresses 0x00 to 0x07. Every other address in the 256-byte space reads as zero and ignores writes. No error is reported for those accesses.

On the first clock edge after reset is released, the bank reloads its defaults. If the 3-bit configuration-select input is 000 at that edge, the per-port disable flags and per-port non-removable flags are also taken from strap pins. All other bits keep their internal defaults. After that edge the strap pins have no further effect. A `load_allowed` input gates every write, so the configuration can be frozen once the host or loader has finished.

Top module: `hubcfg_regbank`

## Requirements
- R1: While reset is asserted, reading the defined addresses returns these defaults: 0x00=8'h24, 0x01=8'h04, 0x02=8'h12, 0x03=8'h25, 0x04=8'h00, 0x05=8'h00, 0x06=8'h9B, 0x07=8'h01.
- R2: A read at any address from 0x08 to 0xFF returns 8'h00.
- R3: A write to an address from 0x08 to 0xFF leaves all eight defined registers unchanged, and no error output exists.
- R4: A write with `wr_en`=1 and `load_allowed`=1 to a defined address stores `wr_data` on that clock edge, with reserved bits cleared. The stored value is visible on `rd_data` right after the edge.
- R5: While `load_allowed`=0, writes have no effect on any register.
- R6: At the first rising edge after `rst_n` goes high, if `cfg_sel`=3'b000, the following bits are loaded from straps: register 0x04 bits [4:1] take `strap_nonrem[3:0]`, and register 0x05 bits [4:1] take `strap_port_dis[3:0]`. Bit n+1 is port n. All other bits take their R1 defaults.
- R7: If `cfg_sel` is not 3'b000 at that load edge, the strap pins are ignored, and registers 0x04 and 0x05 hold their defaults of 8'h00.
- R8: The strap pins are sampled only at the load edge. Later changes on them do not alter any register.
- R9: In registers 0x04 and 0x05, bit 0 and bits [7:5] are reserved. They are always stored as 0 and always read 0, whatever is written.
- R10: A write presented on the load edge itself is dropped. The load result of R6 or R7 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 3 | Configuration select; 000 enables the strap overlay at load |
| strap_port_dis | input | 4 | Per-port disable straps, port 0 in bit 0 |
| strap_nonrem | input | 4 | Per-port non-removable straps, port 0 in bit 0 |
| load_allowed | input | 1 | Write gate; writes are dropped while low |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Byte at `addr`, zero for undefined addresses |

## Verification
The hardest situation to reach from the ports is the single load edge right after reset release. On that edge the strap values, the mode select and a competing write all meet. The stimulus repeats reset with different strap patterns and select codes. It places a write on exactly that edge, then changes the straps afterwards, to show that only the sampled values survive. A behavioural model predicts every register byte, and the output is compared on every cycle across a random mix of defined, undefined and frozen accesses.

// File: rtl/hubcfg_pkg.sv
package hubcfg_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int NUM_REGS   = 8;
    localparam int N_PORTS    = 4;
    localparam int SEL_W      = 3;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int IDX_NONREM = 4;
    localparam int IDX_PDIS   = 5;

    typedef logic [DATA_W-1:0] cfg_byte_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0] cfg_bank_t;

    function automatic cfg_byte_t reg_default(int idx);
        case (idx)
            0:       return 8'h24;
            1:       return 8'h04;
            2:       return 8'h12;
            3:       return 8'h25;
            6:       return 8'h9B;
            7:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_byte_t reg_wmask(int idx);
        cfg_byte_t m;
        m = '1;
        if (idx == IDX_NONREM || idx == IDX_PDIS) begin
            m = '0;
            m[N_PORTS:1] = '1;
        end
        return m;
    endfunction
endpackage

// File: rtl/hubcfg_load_ctrl.sv
module hubcfg_load_ctrl
    import hubcfg_pkg::*;
#(
    parameter int SEL_BITS = SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_BITS-1:0] cfg_sel,
    output logic                load_pulse,
    output logic                overlay_en,
    output logic                loaded
);
    typedef struct packed {
        logic done;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b1;
        loaded     = st_q.done;
        load_pulse = !st_q.done;
        overlay_en = load_pulse && (cfg_sel == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hubcfg_reg_file.sv
module hubcfg_reg_file
    import hubcfg_pkg::*;
#(
    parameter int NREG  = NUM_REGS,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int PORTS = N_PORTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_pulse,
    input  logic                       overlay_en,
    input  logic [PORTS-1:0]           strap_nonrem,
    input  logic [PORTS-1:0]           strap_port_dis,
    input  logic                       wr_go,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wr_data,
    output logic [NREG-1:0][DW-1:0]    regs
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
    } bank_st_t;

    bank_st_t bank_d, bank_q;
    logic     addr_hit;
    logic [IW-1:0] addr_idx;

    assign addr_hit = (addr < AW'(NREG));
    assign addr_idx = addr[IW-1:0];

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NREG; i++) begin
            if (load_pulse) begin
                bank_d.r[i] = reg_default(i);
            end else if (wr_go && addr_hit && addr_idx == IW'(i)) begin
                bank_d.r[i] = wr_data & reg_wmask(i);
            end
        end
        if (overlay_en) begin
            bank_d.r[IDX_NONREM][PORTS:1] = strap_nonrem;
            bank_d.r[IDX_PDIS][PORTS:1]   = strap_port_dis;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank_q.r[i] <= reg_default(i);
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q.r;
endmodule

// File: rtl/hubcfg_rd_mux.sv
module hubcfg_rd_mux
    import hubcfg_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W
) (
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [AW-1:0]           addr,
    output logic [DW-1:0]           rd_data
);
    localparam int IW = $clog2(NREG);

    always_comb begin
        rd_data = '0;
        if (addr < AW'(NREG)) rd_data = regs[addr[IW-1:0]];
    end
endmodule

// File: rtl/hubcfg_regbank.sv
module hubcfg_regbank
    import hubcfg_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int PORTS = N_PORTS,
    parameter int SELW  = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SELW-1:0]  cfg_sel,
    input  logic [PORTS-1:0] strap_port_dis,
    input  logic [PORTS-1:0] strap_nonrem,
    input  logic             load_allowed,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data
);
    logic                        ld_pulse;
    logic                        ld_overlay;
    logic                        ld_done;
    logic                        wr_go;
    logic [NUM_REGS-1:0][DW-1:0] bank_regs;

    hubcfg_load_ctrl #(.SEL_BITS(SELW)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel    (cfg_sel),
        .load_pulse (ld_pulse),
        .overlay_en (ld_overlay),
        .loaded     (ld_done)
    );

    assign wr_go = wr_en && load_allowed && ld_done;

    hubcfg_reg_file #(.NREG(NUM_REGS), .DW(DW), .AW(AW), .PORTS(PORTS)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_pulse     (ld_pulse),
        .overlay_en     (ld_overlay),
        .strap_nonrem   (strap_nonrem),
        .strap_port_dis (strap_port_dis),
        .wr_go          (wr_go),
        .addr           (addr),
        .wr_data        (wr_data),
        .regs           (bank_regs)
    );

    hubcfg_rd_mux #(.NREG(NUM_REGS), .DW(DW), .AW(AW)) u_rd (
        .regs    (bank_regs),
        .addr    (addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/hubcfg_regbank_chk.sv
module hubcfg_regbank_chk
    import hubcfg_pkg::*;
(
    input logic                              clk,
    input logic                              rst_n,
    input logic                              load_allowed,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 addr,
    input logic [DATA_W-1:0]                 wr_data,
    input logic [DATA_W-1:0]                 rd_data,
    input logic                              loaded,
    input logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);
    localparam cfg_byte_t PORT_MASK = reg_wmask(IDX_PDIS);

    AST_UNDEF_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(NUM_REGS)) |-> (rd_data == '0)); // R2

    AST_UNDEF_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && wr_en && addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs)); // R3

    AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && wr_en && load_allowed && addr < ADDR_W'(NUM_REGS)) |=>
        (regs[$past(addr[IDX_W-1:0])] ==
         ($past(wr_data) & reg_wmask(int'($past(addr[IDX_W-1:0])))))); // R4

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !load_allowed) |=> $stable(regs)); // R5

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded); // R8

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs[IDX_NONREM] & ~PORT_MASK) == '0) &&
        ((regs[IDX_PDIS] & ~PORT_MASK) == '0)); // R9
endmodule

bind hubcfg_regbank hubcfg_regbank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_allowed (load_allowed),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .loaded       (ld_done),
    .regs         (bank_regs)
);

// File: tb/tb_hubcfg_regbank.sv
module tb_hubcfg_regbank;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_sel = 3'b000;
    logic [3:0] strap_port_dis = 4'h0;
    logic [3:0] strap_nonrem = 4'h0;
    logic       load_allowed = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int  mdl[8];
    bit  mloaded;
    int  n_run = 0;
    int  n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hubcfg_regbank dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
        .strap_port_dis(strap_port_dis), .strap_nonrem(strap_nonrem),
        .load_allowed(load_allowed), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic int exp_def(int i);
        int t[8] = '{'h24, 'h04, 'h12, 'h25, 'h00, 'h00, 'h9B, 'h01};
        return t[i];
    endfunction

    function automatic int exp_mask(int i);
        return (i == 4 || i == 5) ? 'h1E : 'hFF;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, addr, act, exp);
        end
    endtask

    function automatic int expect_rd(int a);
        return (a < 8) ? mdl[a] : 0;
    endfunction

    // Entered and left at a falling edge; compares rd_data every cycle.
    task automatic step(bit we, int a, int d, bit la, string tag);
        wr_en = we; addr = 8'(a); wr_data = 8'(d); load_allowed = la;
        @(posedge clk);
        #1;
        if (!mloaded) begin
            for (int i = 0; i < 8; i++) mdl[i] = exp_def(i);
            if (cfg_sel == 3'b000) begin
                mdl[4] = int'(strap_nonrem) << 1;
                mdl[5] = int'(strap_port_dis) << 1;
            end
            mloaded = 1;
        end else if (we && la && a < 8) begin
            mdl[a] = d & exp_mask(a);
        end
        @(negedge clk);
        chk(tag, int'(rd_data), expect_rd(a));
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 8; a++) step(1'b0, a, 0, 1'b1, tag);
    endtask

    task automatic do_reset(logic [2:0] sel, logic [3:0] pdis, logic [3:0] nrem);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        cfg_sel = sel; strap_port_dis = pdis; strap_nonrem = nrem;
        for (int i = 0; i < 8; i++) mdl[i] = exp_def(i);
        mloaded = 0;
        for (int a = 0; a < 8; a++) begin
            addr = 8'(a);
            #1;
            chk("R1", int'(rd_data), exp_def(a));
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Overlay mode, with a write on the load edge (R10, R6)
        do_reset(3'b000, 4'b1010, 4'b0101);
        step(1'b1, 4, 'hFF, 1'b1, "R10");
        chk("R6", int'(rd_data), 'h0A);
        step(1'b0, 5, 0, 1'b1, "R6");
        chk("R6", int'(rd_data), 'h14);
        // Later strap changes have no effect (R8)
        strap_port_dis = 4'hF; strap_nonrem = 4'hF;
        step(1'b0, 4, 0, 1'b1, "R8");
        step(1'b0, 5, 0, 1'b1, "R8");
        sweep("R6");
        // Normal writes and reserved bits
        step(1'b1, 2, 'hA5, 1'b1, "R4");
        step(1'b1, 7, 'h3C, 1'b1, "R4");
        step(1'b1, 4, 'hFF, 1'b1, "R9");
        chk("R9", int'(rd_data), 'h1E);
        step(1'b1, 5, 'hE1, 1'b1, "R9");
        chk("R9", int'(rd_data), 'h00);
        // Undefined addresses
        step(1'b1, 8, 'h77, 1'b1, "R2");
        step(1'b1, 'hFF, 'h55, 1'b1, "R3");
        step(1'b1, 'h80, 'hAA, 1'b1, "R3");
        step(1'b1, 'h0C, 'h12, 1'b1, "R3");
        sweep("R3");
        for (int a = 8; a < 256; a += 37) step(1'b0, a, 0, 1'b1, "R2");
        // Frozen bank
        step(1'b1, 2, 'h11, 1'b0, "R5");
        step(1'b1, 6, 'h22, 1'b0, "R5");
        step(1'b1, 4, 'h06, 1'b0, "R5");
        sweep("R5");
        step(1'b1, 6, 'h22, 1'b1, "R4");
        // Non-overlay mode ignores straps (R7)
        do_reset(3'b101, 4'hF, 4'hF);
        step(1'b0, 4, 0, 1'b1, "R7");
        chk("R7", int'(rd_data), 'h00);
        step(1'b0, 5, 0, 1'b1, "R7");
        sweep("R7");
        // Another overlay pattern
        do_reset(3'b000, 4'b0011, 4'b1100);
        step(1'b0, 5, 0, 1'b1, "R6");
        step(1'b0, 4, 0, 1'b1, "R6");
        // Random mix
        for (int k = 0; k < 400; k++) begin
            int a;
            a = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 8);
            step(1'($urandom % 2), a, int'($urandom % 256), 1'($urandom % 4 != 0), "R4");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule